// File: doc/BRIEF.md
# Root-Port Interrupt Aggregator

This block gathers up to 32 interrupt sources that belong to one root port and presents them to a parent controller as a single interrupt line. Software sees a pending register, a mask register and two write-only mask-update addresses on a simple valid/write/address/data bus. The lowest four sources are legacy level-sensitive lines, and their pending bits mirror the input. Every other source is an event: a 0-to-1 transition on its input latches a pending bit, which stays set until software writes a one to that bit of the pending register.

Sources of note in the event class are link-up (bit 12), link-down (bit 14), completion timeout (bit 23) and tunnel error (bit 31). Pending bits latch whether or not the source is masked. Unmasking a source with a stored event therefore raises the output. After reset every source is masked and nothing is pending.

Top module: `port_irq_agg`

## Requirements
- R1: After reset the mask reads 0xFFFFFFFF at offset 0x104, the pending register reads 0 at offset 0x100, `irq_o` is 0, and `reg_rdata_o` is 0.
- R2: A write to offset 0x108 masks (sets) every mask bit whose data bit is one. Mask bits whose data bit is zero keep their value.
- R3: A write to offset 0x10C unmasks (clears) every mask bit whose data bit is one. Mask bits whose data bit is zero keep their value.
- R4: A read of offset 0x104 returns the raw mask. A read of any offset other than 0x100 or 0x104 returns 0. Read data appears on `reg_rdata_o` after the clock edge that accepts the read, and holds until the next read.
- R5: Pending bits 0 to 3 equal the source input as sampled at the previous clock edge. Writes to offset 0x100 have no effect on these bits.
- R6: Pending bits 4 to 31 become set on the clock edge where the input is 1 and was 0 at the previous edge. They remain set after the input falls.
- R7: A write to offset 0x100 clears every pending bit from 4 to 31 whose data bit is one. Bits whose data bit is zero are unchanged.
- R8: When a rising edge of an event source coincides with a clearing write to the same bit, the bit ends up set.
- R9: Event bits latch while masked and do not raise `irq_o` while masked.
- R10: `irq_o` is 1 exactly one clock after some pending bit is set while its mask bit is clear. It is 0 one clock after no such bit exists.
- R11: A write to offset 0x104 leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source lines, bit n is source n |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt to the parent controller |

## Verification
Level sources are driven high and low with pending-register writes interleaved. This separates mirrored bits from latched bits and shows that writes cannot clear a mirrored bit. Event sources are pulsed and then released, cleared with selective and all-zero write masks, and raised in the same cycle as a clear. That last pattern distinguishes set-priority from clear-priority on the shared bit. The output line is tracked through masked events, a later unmask, a clear, and a level source going high and low, counting edges to pin down the single register stage of latency.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_PEND = 12'h100;
  localparam logic [REG_AW-1:0] OFS_MASK = 12'h104;
  localparam logic [REG_AW-1:0] OFS_MSET = 12'h108;
  localparam logic [REG_AW-1:0] OFS_MCLR = 12'h10C;

  typedef struct packed {
    logic pend_clr;
    logic mask_set;
    logic mask_clr;
  } wr_strobe_t;
endpackage

// File: rtl/irqagg_regif.sv
module irqagg_regif #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                valid_i,
  input  logic                                write_i,
  input  logic [irqagg_pkg::REG_AW-1:0]       addr_i,
  input  logic [NUM_SRC-1:0]                  pend_i,
  input  logic [NUM_SRC-1:0]                  mask_i,
  output irqagg_pkg::wr_strobe_t              wstb_o,
  output logic [NUM_SRC-1:0]                  rdata_o
);
  import irqagg_pkg::*;

  logic               rd_en;
  logic [NUM_SRC-1:0] rdata_d, rdata_q;

  always_comb begin
    wstb_o          = '0;
    wstb_o.pend_clr = valid_i && write_i && (addr_i == OFS_PEND);
    wstb_o.mask_set = valid_i && write_i && (addr_i == OFS_MSET);
    wstb_o.mask_clr = valid_i && write_i && (addr_i == OFS_MCLR);
  end

  assign rd_en = valid_i && !write_i;

  always_comb begin
    unique case (addr_i)
      OFS_PEND: rdata_d = pend_i;
      OFS_MASK: rdata_d = mask_i;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  p_mask_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !write_i && addr_i == OFS_MASK) |=> (rdata_o == $past(mask_i)));

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && !write_i) |=> $stable(rdata_o));
endmodule

// File: rtl/irqagg_mask.sv
module irqagg_mask #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_we_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] bits_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic               mask_en;
  logic [NUM_SRC-1:0] mask_d, mask_q;

  assign mask_en = set_we_i || clr_we_i;

  always_comb begin
    mask_d = mask_q;
    if (set_we_i) begin
      mask_d = mask_q | bits_i;
    end else if (clr_we_i) begin
      mask_d = mask_q & ~bits_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  p_set_masks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we_i |=> ((mask_o & $past(bits_i)) == $past(bits_i)));

  p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we_i |=> ((mask_o & ~$past(bits_i)) == ($past(mask_o) & ~$past(bits_i))));

  p_clr_unmasks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !set_we_i) |=> ((mask_o & $past(bits_i)) == '0));

  p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we_i || clr_we_i) |=> $stable(mask_o));
endmodule

// File: rtl/irqagg_status.sv
module irqagg_status #(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_LEVEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] bits_i,
  output logic [NUM_SRC-1:0] pend_o
);
  localparam logic [NUM_SRC-1:0] LVL_MSK  = NUM_SRC'((64'd1 << NUM_LEVEL) - 64'd1);
  localparam logic [NUM_SRC-1:0] EDGE_MSK = ~LVL_MSK;

  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] pend_d, pend_q;

  assign rise = src_i & ~src_q;
  assign clr  = clr_we_i ? bits_i : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (i < NUM_LEVEL) begin : g_lvl
      assign pend_d[i] = src_i[i];
    end else begin : g_edge
      assign pend_d[i] = rise[i] | (pend_q[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
    end
  end

  p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (pend_o[NUM_LEVEL-1:0] == $past(src_i[NUM_LEVEL-1:0])));

  p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_o & ~clr) & ~pend_o & EDGE_MSK) == '0));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr & ~rise) & pend_o & EDGE_MSK) == '0));

  p_rise_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise) & ~pend_o & EDGE_MSK) == '0));
endmodule

// File: rtl/port_irq_agg.sv
module port_irq_agg #(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_LEVEL = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            src_i,
  input  logic                          reg_valid_i,
  input  logic                          reg_write_i,
  input  logic [irqagg_pkg::REG_AW-1:0] reg_addr_i,
  input  logic [NUM_SRC-1:0]            reg_wdata_i,
  output logic [NUM_SRC-1:0]            reg_rdata_o,
  output logic                          irq_o
);
  irqagg_pkg::wr_strobe_t wstb;
  logic [NUM_SRC-1:0]     pend;
  logic [NUM_SRC-1:0]     mask;
  logic                   irq_d, irq_q;

  irqagg_regif #(.NUM_SRC(NUM_SRC)) u_regif (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (reg_valid_i),
    .write_i (reg_write_i),
    .addr_i  (reg_addr_i),
    .pend_i  (pend),
    .mask_i  (mask),
    .wstb_o  (wstb),
    .rdata_o (reg_rdata_o)
  );

  irqagg_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we_i (wstb.mask_set),
    .clr_we_i (wstb.mask_clr),
    .bits_i   (reg_wdata_i),
    .mask_o   (mask)
  );

  irqagg_status #(.NUM_SRC(NUM_SRC), .NUM_LEVEL(NUM_LEVEL)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .clr_we_i (wstb.pend_clr),
    .bits_i   (reg_wdata_i),
    .pend_o   (pend)
  );

  assign irq_d = |(pend & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~mask) == '0) |=> !irq_o);

  p_unmasked_fires_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~mask) != '0) |=> irq_o);
endmodule

// File: tb/port_irq_agg_test.sv
module port_irq_agg_test;
  localparam logic [11:0] A_PEND = 12'h100;
  localparam logic [11:0] A_MASK = 12'h104;
  localparam logic [11:0] A_MSET = 12'h108;
  localparam logic [11:0] A_MCLR = 12'h10C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src;
  logic        valid, write;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  int          n_vec = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  port_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .reg_valid_i(valid), .reg_write_i(write), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    d = rdata;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 1'b0; src = '0; valid = 1'b0; write = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    chk("R1 rdata in reset", rdata, 32'd0);
    rst_n = 1'b1;
    rd(A_MASK, d); chk("R1 mask after reset", d, 32'hFFFF_FFFF);
    rd(A_PEND, d); chk("R1 pending after reset", d, 32'd0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_MCLR, 32'h0000_1001); rd(A_MASK, d); chk("R3 clear selected", d, 32'hFFFF_EFFE);
    wr(A_MCLR, 32'h0);         rd(A_MASK, d); chk("R3 zero clears nothing", d, 32'hFFFF_EFFE);
    wr(A_MSET, 32'h0000_1000); rd(A_MASK, d); chk("R2 set selected", d, 32'hFFFF_FFFE);
    wr(A_MSET, 32'h0);         rd(A_MASK, d); chk("R2 zero sets nothing", d, 32'hFFFF_FFFE);
    wr(A_MASK, 32'h0);         rd(A_MASK, d); chk("R11 raw mask write ignored", d, 32'hFFFF_FFFE);
    rd(A_MSET, d); chk("R4 set address reads zero", d, 32'd0);
    rd(A_MCLR, d); chk("R4 clear address reads zero", d, 32'd0);
    wr(A_MSET, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    drive(32'h5);
    rd(A_PEND, d); chk("R5 level bits follow", d, 32'h5);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, d); chk("R5 write cannot clear level", d, 32'h5);
    drive(32'h0);
    rd(A_PEND, d); chk("R5 level bits drop", d, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    drive(32'h0000_5000);
    rd(A_PEND, d); chk("R6 link events latched", d, 32'h0000_5000);
    drive(32'h0);
    rd(A_PEND, d); chk("R6 latched after input falls", d, 32'h0000_5000);
    wr(A_PEND, 32'h0000_1000);
    rd(A_PEND, d); chk("R7 selective clear", d, 32'h0000_4000);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); chk("R7 zero clears nothing", d, 32'h0000_4000);
    wr(A_PEND, 32'h0000_4000);
    rd(A_PEND, d); chk("R7 final clear", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    drive(32'h0080_0000);
    drive(32'h0);
    @(negedge clk);
    src = 32'h0080_0000;
    valid = 1'b1; write = 1'b1; addr = A_PEND; wdata = 32'h0080_0000;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; wdata = '0;
    rd(A_PEND, d); chk("R8 rise beats clear", d, 32'h0080_0000);
    drive(32'h0);
    wr(A_PEND, 32'h0080_0000);
    rd(A_PEND, d); chk("R8 plain clear after", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    drive(32'h8000_0000);
    drive(32'h0);
    repeat (2) @(negedge clk);
    chk("R9 masked event silent", {31'd0, irq}, 32'd0);
    rd(A_PEND, d); chk("R9 masked event latched", d, 32'h8000_0000);
    wr(A_MCLR, 32'h8000_0000);
    chk("R10 not yet after unmask", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R10 irq after unmask", {31'd0, irq}, 32'd1);
    wr(A_PEND, 32'h8000_0000);
    @(negedge clk);
    chk("R10 irq drops after clear", {31'd0, irq}, 32'd0);
    wr(A_MCLR, 32'h0000_0001);
    drive(32'h1);
    @(negedge clk);
    chk("R10 latency level bit", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R10 level bit raises irq", {31'd0, irq}, 32'd1);
    drive(32'h0);
    repeat (2) @(negedge clk);
    chk("R10 level bit released", {31'd0, irq}, 32'd0);
    wr(A_MSET, 32'hFFFF_FFFF);
  endtask

  initial begin
    t_reset();
    t_mask();
    t_level();
    t_edge();
    t_race();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule